// File: doc/BRIEF.md
# D-PHY Receiver Bring-Up Sequencer

This block brings a D-PHY receiver out of reset and programs it for a requested data rate. Software, or a higher-level controller, presents a per-lane rate in Mbps and a lane count of one to four, then pulses a start request. The block translates the rate into a 6-bit frequency-band code using a fixed range table. It then steps through a fixed power-up sequence on the PHY's lane-control and test-port signals: it releases the force modes, disables lane turnaround, enables the requested lanes, pulses test clear, and finally programs the receive-control and settle-time registers through the test port.

Every test-port register write is bit-banged as six ordered signal steps. The test data-in bus carries the register code on the falling edge of the test clock and the register value on its rising edge. Each signal step is held for a programmable number of system clock cycles. The two waits around the test-clear pulse use a separate programmable count, which stands in for the hundred-microsecond delays.

A rate with no usable band, or an illegal lane count, is flagged as a configuration error and starts nothing. A separate power-off request clears the lane enables.

Top module: `dphyBringupTop`

## Requirements
- R1: The band is the code of the first entry, in ascending order of upper bound, whose upper bound is at or above `rateMbps`. Examples: 90 gives 0x10, 129 gives 0x01, 250 gives 0x04, 1000 gives 0x2a, 1500 gives 0x3c. Each of the four data lanes is written with value band<<1.
- R2: A start request whose band is 0x00 (any rate of 89 or less, or above 1500), or whose `laneCount` is 0 or above 4, sets `cfgError`. In that case `busy` stays low and no test-port or lane output changes. A later accepted start clears `cfgError`.
- R3: Before any register write, `forceRxMode`, `forceStopMode` and `turnRequest` are driven to 0 and `turnDisable` to 0xF. Out of reset the three force/request fields are 0xF and `turnDisable` is 0.
- R4: `laneEnable` is set to a mask with the low `laneCount` bits set, for example 0b0011 for two lanes.
- R5: `testClk` is high when `testClear` rises. `testClear` stays high for `waitTicks` cycles, and a further `waitTicks` cycles pass after it falls before the first write begins.
- R6: Each write drives data-in to the code, then enable to 1, then clock to 0, then enable to 0, then data-in to the value, then clock to 1. `testEnable` is therefore high at each clock fall and low at each clock rise, for 2×`stepTicks` cycles.
- R7: Exactly seven writes occur, as (code, value) pairs in this order: (0x34,0), (0x44,d), (0x54,d), (0x84,d), (0x94,d), (0x75,0x04), (0x00,0), where d = band<<1.
- R8: A `powerOffReq` pulse while idle clears `laneEnable` to zero.
- R9: Each signal step is held for `stepTicks` cycles, with 0 treated as 1. `busy` is high for exactly 48×`stepTicks` + 2×`waitTicks` cycles after an accepted start.
- R10: A start request while `busy` is ignored. The running sequence keeps its original configuration and duration.
- R11: `done` pulses high for exactly one cycle, in the cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin bring-up with the current rate and lane count |
| powerOffReq | input | 1 | Clear lane enables (idle only) |
| rateMbps | input | 11 | Requested per-lane data rate in Mbps |
| laneCount | input | 3 | Number of data lanes, 1 to 4 |
| stepTicks | input | 8 | Cycles each signal step is held |
| waitTicks | input | 16 | Cycles of each wait around test clear |
| laneEnable | output | 4 | Per-lane receiver enable |
| forceRxMode | output | 4 | Per-lane force-receive control |
| forceStopMode | output | 4 | Per-lane force-stop control |
| turnRequest | output | 4 | Per-lane turnaround request |
| turnDisable | output | 4 | Per-lane turnaround disable |
| testClk | output | 1 | Test-port clock |
| testClear | output | 1 | Test-port clear |
| testEnable | output | 1 | Test-port enable (code phase) |
| testDataIn | output | 8 | Test-port data-in bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cfgError | output | 1 | Last start request had an unusable configuration |

## Verification
The embedded properties assume that the rate, lane count and tick counts stay stable from the accepted start until `done`. They also assume that `powerOffReq` is not raised during a run, since it is honoured only when the block is idle. The directed stimulus changes configuration inputs only between runs. The one exception is a deliberate start request, with a different rate and lane count, issued mid-run; in that case only the start pulse changes and the running sequence is expected to ignore it. All inputs are driven half a cycle away from the sampling edge, and tick counts are kept small enough that each run fits well inside the bench timeout.

// File: rtl/dphyBringupPkg.sv
package dphyBringupPkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_FORCE_RX, SEL_FORCE_STOP, SEL_TURN_REQ, SEL_TURN_DIS,
    SEL_LANE_EN, SEL_TCLK, SEL_TCLR, SEL_TEN, SEL_TDIN
  } sigSel_e;

  typedef struct packed {
    logic    we;
    sigSel_e sel;
    logic [7:0] val;
  } ctrlStrobe_t;

  localparam int PRE_STEPS   = 8;
  localparam int WR_PHASES   = 6;
  localparam int NUM_WRITES  = 7;
  localparam int NUM_STEPS   = PRE_STEPS + WR_PHASES * NUM_WRITES;
  localparam int CLR_ON_STEP = 6;
  localparam int CLR_OFF_STEP = 7;

  // Ascending upper bounds; first bound at or above the rate wins.
  function automatic logic [5:0] rateToBand(input logic [15:0] r);
    if      (r <=   89) return 6'h00;
    else if (r <=   99) return 6'h10;
    else if (r <=  109) return 6'h20;
    else if (r <=  129) return 6'h01;
    else if (r <=  139) return 6'h11;
    else if (r <=  149) return 6'h21;
    else if (r <=  169) return 6'h02;
    else if (r <=  179) return 6'h12;
    else if (r <=  199) return 6'h22;
    else if (r <=  219) return 6'h03;
    else if (r <=  239) return 6'h13;
    else if (r <=  249) return 6'h23;
    else if (r <=  269) return 6'h04;
    else if (r <=  299) return 6'h14;
    else if (r <=  329) return 6'h05;
    else if (r <=  359) return 6'h15;
    else if (r <=  399) return 6'h25;
    else if (r <=  449) return 6'h06;
    else if (r <=  499) return 6'h16;
    else if (r <=  549) return 6'h07;
    else if (r <=  599) return 6'h17;
    else if (r <=  649) return 6'h08;
    else if (r <=  699) return 6'h18;
    else if (r <=  749) return 6'h09;
    else if (r <=  799) return 6'h19;
    else if (r <=  849) return 6'h29;
    else if (r <=  899) return 6'h39;
    else if (r <=  949) return 6'h0a;
    else if (r <=  999) return 6'h1a;
    else if (r <= 1049) return 6'h2a;
    else if (r <= 1099) return 6'h3a;
    else if (r <= 1149) return 6'h0b;
    else if (r <= 1199) return 6'h1b;
    else if (r <= 1249) return 6'h2b;
    else if (r <= 1299) return 6'h3b;
    else if (r <= 1349) return 6'h0c;
    else if (r <= 1399) return 6'h1c;
    else if (r <= 1449) return 6'h2c;
    else if (r <= 1500) return 6'h3c;
    else                return 6'h00;
  endfunction

  function automatic logic [7:0] writeCode(input int idx);
    case (idx)
      0: return 8'h34;
      1: return 8'h44;
      2: return 8'h54;
      3: return 8'h84;
      4: return 8'h94;
      5: return 8'h75;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] writeValue(input int idx, input logic [5:0] band);
    case (idx)
      1, 2, 3, 4: return {1'b0, band, 1'b0};
      5:          return 8'h04;
      default:    return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/dphyBringupCtrl.sv
module dphyBringupCtrl
  import dphyBringupPkg::*;
#(
  parameter int RATE_W    = 11,
  parameter int LANE_W    = 3,
  parameter int MAX_LANES = 4,
  parameter int HOLD_W    = 8,
  parameter int WAIT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              powerOffReq,
  input  logic [RATE_W-1:0] rateMbps,
  input  logic [LANE_W-1:0] laneCount,
  input  logic [HOLD_W-1:0] stepTicks,
  input  logic [WAIT_W-1:0] waitTicks,
  output ctrlStrobe_t       strobe,
  output logic              busy,
  output logic              done,
  output logic              cfgError
);

  localparam int CNT_W  = (HOLD_W > WAIT_W) ? HOLD_W : WAIT_W;
  localparam int STEP_W = $clog2(NUM_STEPS);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e               state;
  logic [STEP_W-1:0]    stepIdx;
  logic [CNT_W-1:0]     holdCnt;
  logic [CNT_W-1:0]     holdLim;
  logic [5:0]           bandQ;
  logic [MAX_LANES-1:0] maskQ;

  logic [5:0]           reqBand;
  logic [MAX_LANES-1:0] reqMask;
  logic                 reqValid;
  logic                 lastTick;
  sigSel_e              stepSel;
  logic [7:0]           stepVal;

  assign reqBand = rateToBand(16'(rateMbps));

  always_comb begin
    for (int i = 0; i < MAX_LANES; i++) reqMask[i] = (int'(laneCount) > i);
  end

  assign reqValid = (reqBand != 6'h00) && (laneCount != '0) && (int'(laneCount) <= MAX_LANES);

  always_comb begin
    holdLim = ((int'(stepIdx) == CLR_ON_STEP) || (int'(stepIdx) == CLR_OFF_STEP))
              ? CNT_W'(waitTicks) : CNT_W'(stepTicks);
    if (holdLim == '0) holdLim = CNT_W'(1);
  end

  assign lastTick = (holdCnt == holdLim - CNT_W'(1));

  always_comb begin
    int rel;
    int wIdx;
    stepSel = SEL_NONE;
    stepVal = 8'h00;
    rel  = int'(stepIdx) - PRE_STEPS;
    wIdx = (rel < 0) ? 0 : rel / WR_PHASES;
    if (rel < 0) begin
      case (int'(stepIdx))
        0: stepSel = SEL_FORCE_RX;
        1: stepSel = SEL_FORCE_STOP;
        2: stepSel = SEL_TURN_REQ;
        3: begin stepSel = SEL_TURN_DIS; stepVal = 8'({MAX_LANES{1'b1}}); end
        4: begin stepSel = SEL_LANE_EN;  stepVal = 8'(maskQ); end
        5: begin stepSel = SEL_TCLK;     stepVal = 8'h01; end
        6: begin stepSel = SEL_TCLR;     stepVal = 8'h01; end
        default: stepSel = SEL_TCLR;
      endcase
    end else begin
      case (rel % WR_PHASES)
        0: begin stepSel = SEL_TDIN; stepVal = writeCode(wIdx); end
        1: begin stepSel = SEL_TEN;  stepVal = 8'h01; end
        2: stepSel = SEL_TCLK;
        3: stepSel = SEL_TEN;
        4: begin stepSel = SEL_TDIN; stepVal = writeValue(wIdx, bandQ); end
        default: begin stepSel = SEL_TCLK; stepVal = 8'h01; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepIdx  <= '0;
      holdCnt  <= '0;
      bandQ    <= '0;
      maskQ    <= '0;
      done     <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (startReq) begin
          if (reqValid) begin
            state    <= ST_RUN;
            stepIdx  <= '0;
            holdCnt  <= '0;
            bandQ    <= reqBand;
            maskQ    <= reqMask;
            cfgError <= 1'b0;
          end else begin
            cfgError <= 1'b1;
          end
        end
        default: begin
          if (lastTick) begin
            holdCnt <= '0;
            if (int'(stepIdx) == NUM_STEPS - 1) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              stepIdx <= stepIdx + STEP_W'(1);
            end
          end else begin
            holdCnt <= holdCnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_RUN);

  always_comb begin
    strobe = '0;
    if (state == ST_RUN && holdCnt == '0) begin
      strobe.we  = 1'b1;
      strobe.sel = stepSel;
      strobe.val = stepVal;
    end else if (state == ST_IDLE && powerOffReq && !startReq) begin
      strobe.we  = 1'b1;
      strobe.sel = SEL_LANE_EN;
    end
  end

  // R11
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> ($stable(maskQ) && $stable(bandQ)));

  // R2
  cfg_error_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgError) |-> !busy);

endmodule

// File: rtl/dphyBringupDatapath.sv
module dphyBringupDatapath
  import dphyBringupPkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  output logic [MAX_LANES-1:0] laneEnable,
  output logic [MAX_LANES-1:0] forceRxMode,
  output logic [MAX_LANES-1:0] forceStopMode,
  output logic [MAX_LANES-1:0] turnRequest,
  output logic [MAX_LANES-1:0] turnDisable,
  output logic                 testClk,
  output logic                 testClear,
  output logic                 testEnable,
  output logic [7:0]           testDataIn
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneEnable    <= '0;
      forceRxMode   <= '1;
      forceStopMode <= '1;
      turnRequest   <= '1;
      turnDisable   <= '0;
      testClk       <= 1'b1;
      testClear     <= 1'b0;
      testEnable    <= 1'b0;
      testDataIn    <= '0;
    end else if (strobe.we) begin
      case (strobe.sel)
        SEL_FORCE_RX:   forceRxMode   <= strobe.val[MAX_LANES-1:0];
        SEL_FORCE_STOP: forceStopMode <= strobe.val[MAX_LANES-1:0];
        SEL_TURN_REQ:   turnRequest   <= strobe.val[MAX_LANES-1:0];
        SEL_TURN_DIS:   turnDisable   <= strobe.val[MAX_LANES-1:0];
        SEL_LANE_EN:    laneEnable    <= strobe.val[MAX_LANES-1:0];
        SEL_TCLK:       testClk       <= strobe.val[0];
        SEL_TCLR:       testClear     <= strobe.val[0];
        SEL_TEN:        testEnable    <= strobe.val[0];
        SEL_TDIN:       testDataIn    <= strobe.val;
        default: ;
      endcase
    end
  end

  // R6
  clk_fall_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(testClk) |-> testEnable);

  // R6
  clk_rise_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testClk) |-> !testEnable);

  // R5
  clr_rise_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testClear) |-> testClk);

endmodule

// File: rtl/dphyBringupTop.sv
module dphyBringupTop
  import dphyBringupPkg::*;
#(
  parameter int RATE_W    = 11,
  parameter int LANE_W    = 3,
  parameter int MAX_LANES = 4,
  parameter int HOLD_W    = 8,
  parameter int WAIT_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 powerOffReq,
  input  logic [RATE_W-1:0]    rateMbps,
  input  logic [LANE_W-1:0]    laneCount,
  input  logic [HOLD_W-1:0]    stepTicks,
  input  logic [WAIT_W-1:0]    waitTicks,
  output logic [MAX_LANES-1:0] laneEnable,
  output logic [MAX_LANES-1:0] forceRxMode,
  output logic [MAX_LANES-1:0] forceStopMode,
  output logic [MAX_LANES-1:0] turnRequest,
  output logic [MAX_LANES-1:0] turnDisable,
  output logic                 testClk,
  output logic                 testClear,
  output logic                 testEnable,
  output logic [7:0]           testDataIn,
  output logic                 busy,
  output logic                 done,
  output logic                 cfgError
);

  ctrlStrobe_t strobe;

  dphyBringupCtrl #(
    .RATE_W(RATE_W), .LANE_W(LANE_W), .MAX_LANES(MAX_LANES),
    .HOLD_W(HOLD_W), .WAIT_W(WAIT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .powerOffReq(powerOffReq),
    .rateMbps(rateMbps), .laneCount(laneCount), .stepTicks(stepTicks),
    .waitTicks(waitTicks), .strobe(strobe), .busy(busy), .done(done),
    .cfgError(cfgError)
  );

  dphyBringupDatapath #(.MAX_LANES(MAX_LANES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .laneEnable(laneEnable), .forceRxMode(forceRxMode),
    .forceStopMode(forceStopMode), .turnRequest(turnRequest),
    .turnDisable(turnDisable), .testClk(testClk), .testClear(testClear),
    .testEnable(testEnable), .testDataIn(testDataIn)
  );

endmodule

// File: tb/dphyBringupTop_tb_top.sv
module dphyBringupTop_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_T = 3;
  localparam int WAIT_T = 20;
  localparam int RUN_CYC = 48 * STEP_T + 2 * WAIT_T;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic powerOffReq = 1'b0;
  logic [10:0] rateMbps = '0;
  logic [2:0] laneCount = '0;
  logic [7:0] stepTicks = 8'(STEP_T);
  logic [15:0] waitTicks = 16'(WAIT_T);
  logic [3:0] laneEnable, forceRxMode, forceStopMode, turnRequest, turnDisable;
  logic testClk, testClear, testEnable;
  logic [7:0] testDataIn;
  logic busy, done, cfgError;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dphyBringupTop dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .powerOffReq(powerOffReq),
    .rateMbps(rateMbps), .laneCount(laneCount), .stepTicks(stepTicks),
    .waitTicks(waitTicks), .laneEnable(laneEnable), .forceRxMode(forceRxMode),
    .forceStopMode(forceStopMode), .turnRequest(turnRequest),
    .turnDisable(turnDisable), .testClk(testClk), .testClear(testClear),
    .testEnable(testEnable), .testDataIn(testDataIn), .busy(busy),
    .done(done), .cfgError(cfgError)
  );

  int nChecks = 0;
  int nErrors = 0;

  // Monitor state
  logic monClear = 1'b0;
  logic prevClk;
  logic [7:0] codes [8];
  logic [7:0] datas [8];
  int nWr, enBadFall, enBadRise, busyCyc, doneCyc, clrCyc, enRun, enMax;

  always @(negedge clk) begin
    if (monClear) begin
      nWr = 0; enBadFall = 0; enBadRise = 0; busyCyc = 0; doneCyc = 0;
      clrCyc = 0; enRun = 0; enMax = 0;
      for (int i = 0; i < 8; i++) begin codes[i] = 8'hff; datas[i] = 8'hff; end
    end else begin
      if (prevClk && !testClk) begin
        if (nWr < 8) codes[nWr] = testDataIn;
        if (!testEnable) enBadFall++;
      end
      if (!prevClk && testClk) begin
        if (nWr < 8) datas[nWr] = testDataIn;
        if (testEnable) enBadRise++;
        nWr++;
      end
      if (busy) busyCyc++;
      if (done) doneCyc++;
      if (testClear) clrCyc++;
      if (testEnable) enRun++; else enRun = 0;
      if (enRun > enMax) enMax = enRun;
    end
    prevClk = testClk;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(posedge clk); monClear = 1'b1;
    @(posedge clk); monClear = 1'b0;
  endtask

  task automatic pulseStart(input int rate, input int lanes);
    @(negedge clk);
    rateMbps = 11'(rate); laneCount = 3'(lanes); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 5000 && doneCyc == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkWrites(input int d);
    logic [7:0] expC [7];
    logic [7:0] expD [7];
    expC = '{8'h34, 8'h44, 8'h54, 8'h84, 8'h94, 8'h75, 8'h00};
    expD = '{8'h00, 8'(d), 8'(d), 8'(d), 8'(d), 8'h04, 8'h00};
    check("R7 write count", nWr, 7);
    for (int i = 0; i < 7; i++) begin
      check("R7 write code", int'(codes[i]), int'(expC[i]));
      check("R1 R7 write value", int'(datas[i]), int'(expD[i]));
    end
  endtask

  task automatic t_reset();
    check("R3 reset forceRx", int'(forceRxMode), 4'hf);
    check("R3 reset turnDisable", int'(turnDisable), 0);
    check("R4 reset laneEnable", int'(laneEnable), 0);
    check("R5 reset testClk", int'(testClk), 1);
    check("R9 reset busy", int'(busy), 0);
    check("R11 reset done", int'(done), 0);
    check("R2 reset cfgError", int'(cfgError), 0);
  endtask

  task automatic t_run(input int rate, input int lanes, input int expData, input int expMask);
    clearMon();
    pulseStart(rate, lanes);
    waitDone();
    checkWrites(expData);
    check("R2 cfgError clear", int'(cfgError), 0);
    check("R3 forceRx", int'(forceRxMode), 0);
    check("R3 forceStop", int'(forceStopMode), 0);
    check("R3 turnRequest", int'(turnRequest), 0);
    check("R3 turnDisable", int'(turnDisable), 4'hf);
    check("R4 laneEnable", int'(laneEnable), expMask);
    check("R5 clear width", clrCyc, WAIT_T);
    check("R5 clear released", int'(testClear), 0);
    check("R6 enable at fall", enBadFall, 0);
    check("R6 enable at rise", enBadRise, 0);
    check("R6 enable width", enMax, 2 * STEP_T);
    check("R9 busy cycles", busyCyc, RUN_CYC);
    check("R11 done pulses", doneCyc, 1);
    check("R5 clk idle high", int'(testClk), 1);
  endtask

  task automatic t_cfgErr(input int rate, input int lanes);
    logic [3:0] laneBefore;
    laneBefore = laneEnable;
    clearMon();
    pulseStart(rate, lanes);
    repeat (10) @(negedge clk);
    check("R2 cfgError set", int'(cfgError), 1);
    check("R2 no busy", busyCyc, 0);
    check("R2 no test writes", nWr, 0);
    check("R2 lanes untouched", int'(laneEnable), int'(laneBefore));
  endtask

  task automatic t_powerOff();
    @(negedge clk); powerOffReq = 1'b1;
    @(negedge clk); powerOffReq = 1'b0;
    @(negedge clk);
    check("R8 power-off lanes", int'(laneEnable), 0);
  endtask

  task automatic t_busyIgnore();
    clearMon();
    pulseStart(1000, 4);
    repeat (30) @(negedge clk);
    pulseStart(300, 1);
    waitDone();
    checkWrites(8'h54);
    check("R10 lanes kept", int'(laneEnable), 4'hf);
    check("R10 duration kept", busyCyc, RUN_CYC);
    check("R10 single done", doneCyc, 1);
    check("R10 no error", int'(cfgError), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_run(90, 2, 8'h20, 4'b0011);
    t_run(129, 1, 8'h02, 4'b0001);
    t_run(250, 3, 8'h08, 4'b0111);
    t_run(1500, 4, 8'h78, 4'b1111);
    t_cfgErr(89, 2);
    t_cfgErr(1501, 2);
    t_cfgErr(500, 0);
    t_cfgErr(500, 5);
    t_run(1000, 4, 8'h54, 4'b1111);
    t_powerOff();
    t_busyIgnore();
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule